// File: doc/BRIEF.md
# Protected Interrupt Vector Relocation Control

This block is a small control register inside a microcontroller-style core. It holds a vector-select flag that places the interrupt vector table either at program word address 0 or at the first word of a boot section. The size of that boot section, and so its first word, comes from a 2-bit configuration code. The flag cannot be changed by an ordinary register write. Software must first open a short unlock window, then write the new value before the window closes.

While the unlock window is open, and for one completed instruction after a successful update, the block raises a separate interrupt-hold output. The core combines this output with its own interrupt gating, and the global interrupt-enable flag is never touched. The block also produces a lock-driven interrupt block. Depending on where the vectors sit, an asserted lock input stops interrupts while code runs from the other memory region. A general-purpose pull-up-disable bit shares the register.

Top module: `ivec_reloc_ctrl`

## Requirements
- R1: After synchronous reset, `rd_data`, `vec_base`, `irq_hold`, `irq_block` and `pud` are all 0.
- R2: Register layout: bit 0 is the unlock (change-enable) bit, bit 1 is vector-select, bit 4 is pull-up disable, and bits 2, 3, 5, 6 and 7 always read 0. Writing 1 to bit 0 while the window is closed opens it, and bit 0 then reads 1 for as long as the window stays open.
- R3: A write with bit 0 at 0 while the window is open copies bit 1 into vector-select and closes the window.
- R4: The window stays open for 4 strobed cycles, counted as clock edges with `cyc_en` high after the opening edge. A write on the 4th such edge is accepted and a write on the 5th is not. Edges with `cyc_en` low are not counted.
- R5: A write with bit 0 at 0 while the window is closed, or a write with bit 0 at 1 while it is open, leaves vector-select unchanged. The second case does not restart the window.
- R6: `irq_hold` is 1 from the cycle after the opening write until the window closes. After a valid update it stays 1 until the first clock edge with `insn_done` high that comes after the update edge. It is an output only and carries no global interrupt flag.
- R7: `vec_base` is 0 when vector-select is 0. When vector-select is 1 it is 2^PC_AW - (BOOT_MIN_W << (3 - boot_sz)); with the defaults, codes 0, 1, 2 and 3 give 1024, 1536, 1792 and 1920. It follows vector-select and `boot_sz` one clock later.
- R8: `irq_block` is 1, one clock after its inputs, when vector-select = 1 with `lock_app` = 1 and `in_boot` = 0, or when vector-select = 0 with `lock_boot` = 1 and `in_boot` = 1. Otherwise it is 0.
- R9: Every write loads bit 4 into the pull-up-disable bit, whether or not the window is open, and the `pud` output mirrors it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_en | input | 1 | Per-cycle strobe that advances the unlock window |
| insn_done | input | 1 | Pulse marking an instruction completion |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read value |
| boot_sz | input | 2 | Boot section size code |
| lock_app | input | 1 | Lock guarding the application region |
| lock_boot | input | 1 | Lock guarding the boot region |
| in_boot | input | 1 | Core is executing from the boot region |
| vec_base | output | PC_AW | Interrupt vector base word address |
| irq_hold | output | 1 | Temporary interrupt suppression |
| irq_block | output | 1 | Lock-based interrupt block |
| pud | output | 1 | Pull-up disable bit |

## Verification
The assertions assume that `wr_en`, `wr_data`, `cyc_en` and `insn_done` are steady around each rising edge. They also assume that `insn_done` is a pulse the core raises for at most one cycle per instruction. The stimulus changes every input one time unit after a rising edge, and it raises `insn_done` for exactly one edge when it wants to retire the instruction after an update. The window cases line up writes on exact strobe edges: the 4th (accepted), the 5th (too late), and edges with `cyc_en` low, which are not counted.

// File: rtl/ivec_pkg.sv
package ivec_pkg;
  localparam int REG_W   = 8;
  localparam int CE_BIT  = 0;
  localparam int SEL_BIT = 1;
  localparam int PUD_BIT = 4;

  // First word of the boot section for a size code; code 3 is the smallest section.
  function automatic int unsigned boot_start(input int unsigned aw,
                                             input int unsigned min_w,
                                             input logic [1:0] code);
    int unsigned span;
    span = min_w << (3 - int'(code));
    return (1 << aw) - span;
  endfunction
endpackage

// File: rtl/ivec_unlock.sv
module ivec_unlock
  import ivec_pkg::*;
#(
  parameter int WIN_CYC = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cyc_en,
  input  logic             insn_done,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic             ce_o,
  output logic             sel_o,
  output logic             pud_o,
  output logic             hold_o
);
  localparam int CW = $clog2(WIN_CYC + 1);

  logic          ce_q, ce_n;
  logic          sel_q, sel_n;
  logic          pud_q, pud_n;
  logic          pend_q, pend_n;
  logic          hold_q;
  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    ce_n   = ce_q;
    sel_n  = sel_q;
    pud_n  = pud_q;
    pend_n = pend_q;
    cnt_n  = cnt_q;
    if (wr_en) pud_n = wr_data[PUD_BIT];
    if (pend_q && insn_done) pend_n = 1'b0;
    if (ce_q) begin
      if (wr_en && !wr_data[CE_BIT]) begin
        sel_n  = wr_data[SEL_BIT];
        ce_n   = 1'b0;
        cnt_n  = '0;
        pend_n = 1'b1;
      end else if (cyc_en) begin
        if (cnt_q == CW'(1)) begin
          ce_n  = 1'b0;
          cnt_n = '0;
        end else begin
          cnt_n = cnt_q - CW'(1);
        end
      end
    end else if (wr_en && wr_data[CE_BIT]) begin
      ce_n  = 1'b1;
      cnt_n = CW'(WIN_CYC);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_q   <= 1'b0;
      sel_q  <= 1'b0;
      pud_q  <= 1'b0;
      pend_q <= 1'b0;
      hold_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      ce_q   <= ce_n;
      sel_q  <= sel_n;
      pud_q  <= pud_n;
      pend_q <= pend_n;
      hold_q <= ce_n | pend_n;
      cnt_q  <= cnt_n;
    end
  end

  assign ce_o   = ce_q;
  assign sel_o  = sel_q;
  assign pud_o  = pud_q;
  assign hold_o = hold_q;

  // R2
  ce_open_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ce_q) |-> $past(wr_en && wr_data[CE_BIT]));
  // R3 R5
  sel_guard_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sel_q) |-> $past(ce_q && wr_en && !wr_data[CE_BIT]));
  // R4
  win_bound_chk: assert property (@(posedge clk) disable iff (rst)
    ce_q |-> (cnt_q != '0 && cnt_q <= CW'(WIN_CYC)));
  // R6
  hold_cover_chk: assert property (@(posedge clk) disable iff (rst)
    ce_q |-> hold_q);
  // R6
  pend_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(pend_q) |-> $past(insn_done));
endmodule

// File: rtl/ivec_base_map.sv
module ivec_base_map
  import ivec_pkg::*;
#(
  parameter int PC_AW      = 11,
  parameter int BOOT_MIN_W = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel,
  input  logic [1:0]       boot_sz,
  output logic [PC_AW-1:0] vec_base
);
  logic [PC_AW-1:0] start_tab [4];

  for (genvar g = 0; g < 4; g++) begin : g_start
    assign start_tab[g] = PC_AW'(boot_start(PC_AW, BOOT_MIN_W, 2'(g)));
  end

  always_ff @(posedge clk) begin
    if (rst) vec_base <= '0;
    else     vec_base <= sel ? start_tab[boot_sz] : '0;
  end

  // R7
  base_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(sel) |-> vec_base == '0);
endmodule

// File: rtl/ivec_lock_gate.sv
module ivec_lock_gate (
  input  logic clk,
  input  logic rst,
  input  logic sel,
  input  logic lock_app,
  input  logic lock_boot,
  input  logic in_boot,
  output logic irq_block
);
  logic app_side, boot_side;
  assign app_side  = sel  & lock_app  & ~in_boot;
  assign boot_side = ~sel & lock_boot &  in_boot;

  always_ff @(posedge clk) begin
    if (rst) irq_block <= 1'b0;
    else     irq_block <= app_side | boot_side;
  end

  // R8
  block_src_chk: assert property (@(posedge clk) disable iff (rst)
    irq_block |-> $past(lock_app || lock_boot));
endmodule

// File: rtl/ivec_reloc_ctrl.sv
module ivec_reloc_ctrl
  import ivec_pkg::*;
#(
  parameter int PC_AW      = 11,
  parameter int BOOT_MIN_W = 128,
  parameter int WIN_CYC    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cyc_en,
  input  logic             insn_done,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  output logic [7:0]       rd_data,
  input  logic [1:0]       boot_sz,
  input  logic             lock_app,
  input  logic             lock_boot,
  input  logic             in_boot,
  output logic [PC_AW-1:0] vec_base,
  output logic             irq_hold,
  output logic             irq_block,
  output logic             pud
);
  logic ce, sel;

  ivec_unlock #(.WIN_CYC(WIN_CYC)) u_unlock (
    .clk(clk), .rst(rst), .cyc_en(cyc_en), .insn_done(insn_done),
    .wr_en(wr_en), .wr_data(wr_data),
    .ce_o(ce), .sel_o(sel), .pud_o(pud), .hold_o(irq_hold)
  );

  ivec_base_map #(.PC_AW(PC_AW), .BOOT_MIN_W(BOOT_MIN_W)) u_base (
    .clk(clk), .rst(rst), .sel(sel), .boot_sz(boot_sz), .vec_base(vec_base)
  );

  ivec_lock_gate u_gate (
    .clk(clk), .rst(rst), .sel(sel), .lock_app(lock_app),
    .lock_boot(lock_boot), .in_boot(in_boot), .irq_block(irq_block)
  );

  always_comb begin
    rd_data          = '0;
    rd_data[CE_BIT]  = ce;
    rd_data[SEL_BIT] = sel;
    rd_data[PUD_BIT] = pud;
  end

  // R2
  rd_unused_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_data & 8'hEC) == 8'h00);
endmodule

// File: tb/ivec_reloc_ctrl_tb.sv
module ivec_reloc_ctrl_tb;
  localparam int PC_AW = 11;
  localparam int BMIN  = 128;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cyc_en = 1'b1, insn_done = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [1:0] boot_sz = 2'd3;
  logic lock_app = 1'b0, lock_boot = 1'b0, in_boot = 1'b0;
  logic [PC_AW-1:0] vec_base;
  logic irq_hold, irq_block, pud;

  always #4 clk = ~clk;

  ivec_reloc_ctrl #(.PC_AW(PC_AW), .BOOT_MIN_W(BMIN), .WIN_CYC(4)) u_dut (
    .clk(clk), .rst(rst), .cyc_en(cyc_en), .insn_done(insn_done),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .boot_sz(boot_sz),
    .lock_app(lock_app), .lock_boot(lock_boot), .in_boot(in_boot),
    .vec_base(vec_base), .irq_hold(irq_hold), .irq_block(irq_block), .pud(pud)
  );

  typedef enum int {K_RD, K_VEC, K_HOLD, K_BLK, K_PUD} kind_e;
  typedef struct { kind_e kind; int exp; string req; } exp_t;
  exp_t sb[$];
  int vectors = 0, miscompares = 0;
  bit done = 1'b0;

  // Monitor: compares queued expectations away from the active edge.
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      exp_t it;
      int got;
      it = sb.pop_front();
      case (it.kind)
        K_RD:    got = int'(rd_data);
        K_VEC:   got = int'(vec_base);
        K_HOLD:  got = int'(irq_hold);
        K_BLK:   got = int'(irq_block);
        default: got = int'(pud);
      endcase
      vectors++;
      if (got != it.exp) begin
        miscompares++;
        $display("FAIL %s kind=%0d got=%0d expected=%0d", it.req, it.kind, got, it.exp);
      end
    end
  end

  task automatic expect_out(input kind_e k, input int e, input string r);
    exp_t it;
    it.kind = k; it.exp = e; it.req = r;
    sb.push_back(it);
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic retire();
    insn_done = 1'b1;
    tick();
    insn_done = 1'b0;
  endtask

  function automatic int start_of(input int code);
    return (1 << PC_AW) - (BMIN << (3 - code));
  endfunction

  initial begin
    #(8 * 5000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired got=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R1 reset state
    expect_out(K_RD, 0, "R1"); expect_out(K_VEC, 0, "R1");
    expect_out(K_HOLD, 0, "R1"); expect_out(K_BLK, 0, "R1");
    expect_out(K_PUD, 0, "R1");

    // R2 open window, R3 valid update on 2nd strobe, R6 hold until retire
    wr(8'h01);
    expect_out(K_RD, 8'h01, "R2"); expect_out(K_HOLD, 1, "R6");
    tick();
    wr(8'h02);
    expect_out(K_RD, 8'h02, "R3"); expect_out(K_HOLD, 1, "R6");
    tick();
    expect_out(K_HOLD, 1, "R6"); expect_out(K_VEC, start_of(3), "R7");
    retire();
    expect_out(K_HOLD, 0, "R6");

    // R4 expiry with no write after 4 strobes
    wr(8'h01);
    repeat (3) tick();
    expect_out(K_RD, 8'h03, "R4"); expect_out(K_HOLD, 1, "R6");
    tick();
    expect_out(K_RD, 8'h02, "R4"); expect_out(K_HOLD, 0, "R4");

    // R4 late write on 5th strobe is rejected
    wr(8'h01);
    repeat (4) tick();
    wr(8'h00);
    expect_out(K_RD, 8'h02, "R4");

    // R4 write on 4th strobe is accepted
    wr(8'h01);
    repeat (3) tick();
    wr(8'h00);
    expect_out(K_RD, 8'h00, "R4");
    tick();
    expect_out(K_VEC, 0, "R7");
    retire();

    // R5 write with bit0=1 inside window, no restart
    wr(8'h01);
    wr(8'h03);
    expect_out(K_RD, 8'h01, "R5");
    repeat (3) tick();
    expect_out(K_RD, 8'h00, "R5"); expect_out(K_HOLD, 0, "R5");

    // R5 select write with window closed
    wr(8'h02);
    expect_out(K_RD, 8'h00, "R5");

    // R4 edges without strobe not counted
    cyc_en = 1'b0;
    wr(8'h01);
    repeat (5) tick();
    expect_out(K_RD, 8'h01, "R4");
    cyc_en = 1'b1;
    wr(8'h02);
    expect_out(K_RD, 8'h02, "R3");
    retire();

    // R9 pull-up bit independent of window; R2 unused bits read 0
    wr(8'h10);
    expect_out(K_RD, 8'h12, "R9"); expect_out(K_PUD, 1, "R9");
    expect_out(K_HOLD, 0, "R9");
    wr(8'hEC);
    expect_out(K_RD, 8'h02, "R2"); expect_out(K_PUD, 0, "R9");

    // R7 boot size codes
    for (int c = 0; c < 4; c++) begin
      boot_sz = 2'(c);
      tick();
      expect_out(K_VEC, start_of(c), "R7");
    end

    // R8 lock gate with vectors in boot section
    lock_app = 1'b1; in_boot = 1'b0;
    tick();
    expect_out(K_BLK, 1, "R8");
    in_boot = 1'b1;
    tick();
    expect_out(K_BLK, 0, "R8");
    lock_app = 1'b0; lock_boot = 1'b1;
    tick();
    expect_out(K_BLK, 0, "R8");
    // move vectors to application section
    wr(8'h01);
    wr(8'h00);
    tick();
    expect_out(K_BLK, 1, "R8"); expect_out(K_VEC, 0, "R7");
    in_boot = 1'b0;
    tick();
    expect_out(K_BLK, 0, "R8");
    retire();

    tick();
    tick();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule